// File: doc/BRIEF.md
# Write-Protected Serial Presence-Detect Memory

This block is a 256-byte configuration store that a host reaches over a two-wire I2C bus, as used for the identification memory on a memory module. The block samples SCL and SDA with its own system clock, finds START and STOP conditions, and decodes the device-select byte. It then carries out byte writes with a word address, random reads, current-address reads and sequential reads. SDA is open drain: the block only pulls the line low through `sda_oe`.

Two protection rules guard the contents. The lower half (bytes 0 to 127) holds factory data and the bus can never change it. That data is loaded through a separate preload port. The upper half (bytes 128 to 255) accepts bus writes only while the write-protect pin is low. The board is expected to fit a pull-down on that pin, so a pin left unconnected keeps the upper half writable. A blocked write still receives acknowledges for every byte, so the host cannot tell it apart on the bus.

Top module: `spd_eeprom`

## Requirements
- R1: The block acknowledges a select byte whose upper seven bits are 1010 followed by the three `dev_sel` bits, by holding SDA low in the ninth SCL pulse. Bit 0 of that byte is the direction, and 1 means read. A select byte that does not match gets no acknowledge, and every later byte up to the next START is also left unacknowledged.
- R2: In a write transfer, the first byte after the select byte is the word address. Each later byte is a data byte. The block acknowledges the address byte and every data byte, including writes that protection blocks.
- R3: Bytes 0 to 127 never change as a result of a bus write.
- R4: A bus data byte aimed at an address from 128 to 255 is stored when `wp` is low and discarded when `wp` is high. In both cases the word pointer advances by one.
- R5: Read data is sent most significant bit first, starting at the word pointer. The pointer advances by one after each byte and wraps from 255 to 0.
- R6: When the host acknowledges a read byte (SDA low in the ninth pulse), the next byte follows. When the host does not acknowledge it, the block releases SDA and drives nothing more until a START, and the pointer does not advance further.
- R7: A repeated START after the word address, followed by a read select byte, reads from that word address.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP at any point returns the block to idle with SDA released. The word pointer is kept across transfers, so a read that carries no address starts where the last transfer left off.
- R9: While `pre_en` is high, each clock writes `pre_data` to `pre_addr`, at any address and whatever the level of `wp`. Later bus reads return that value.
- R10: The block changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released and the word pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wp | input | 1 | Write protect for the upper half, active high |
| dev_sel | input | 3 | Strap bits compared against select-byte bits 3..1 |
| pre_en | input | 1 | Preload write strobe |
| pre_addr | input | ADDR_W | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
A wrong select decode or a wrong protocol state shows up as a missing or extra acknowledge in the ninth SCL pulse of the byte where it happens, so it is visible within one byte time. A corrupted word pointer, a missed wrap or a protection gate that leaks does not show at once: it appears as a wrong data byte on the next read of the affected address. The bench therefore reads back every address it wrote, including locked and protected ones. It also checks on every clock that the SDA drive holds still while SCL is high, which exposes drive changes made in the wrong phase.

// File: rtl/spd_pkg.sv
package spd_pkg;
   localparam int BYTE_W = 8;
   localparam logic [3:0] SEL_CODE = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } link_st_e;
endpackage

// File: rtl/spd_bus_sync.sv
module spd_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic wp_i,
   output logic scl_s,
   output logic sda_s,
   output logic wp_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int NLINE = 3;
   localparam logic [NLINE-1:0] IDLE_LVL = 3'b011;

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("spd_bus_sync: STAGES must be 2..4");
   end

   logic [NLINE-1:0] in_vec;
   logic [NLINE-1:0] syn;
   logic [1:0]       prv_q;

   assign in_vec = {wp_i, sda_i, scl_i};

   for (genvar g = 0; g < NLINE; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{IDLE_LVL[g]}};
         else        chain_q <= {chain_q[STAGES-2:0], in_vec[g]};
      end
      assign syn[g] = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_q <= 2'b11;
      else        prv_q <= syn[1:0];
   end

   assign scl_s     = syn[0];
   assign sda_s     = syn[1];
   assign wp_s      = syn[2];
   assign scl_rise  = syn[0] & ~prv_q[0];
   assign scl_fall  = ~syn[0] & prv_q[0];
   assign start_det = syn[0] & prv_q[0] & prv_q[1] & ~syn[1];
   assign stop_det  = syn[0] & prv_q[0] & ~prv_q[1] & syn[1];
endmodule

// File: rtl/spd_store.sv
module spd_store #(
   parameter int ADDR_W     = 8,
   parameter bit LOCK_LOWER = 1'b1
) (
   input  logic              clk,
   input  logic              wp_s,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              pre_en,
   input  logic [ADDR_W-1:0] pre_addr,
   input  logic [7:0]        pre_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              commit
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem_q [DEPTH];
   logic       lock_hit;

   if (LOCK_LOWER) begin : g_lock
      assign lock_hit = ~wr_addr[ADDR_W-1];
   end else begin : g_open
      assign lock_hit = 1'b0;
   end

   assign commit = wr_req & ~lock_hit & ~wp_s & ~pre_en;

   always_ff @(posedge clk) begin
      if (pre_en)      mem_q[pre_addr] <= pre_data;
      else if (commit) mem_q[wr_addr]  <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/spd_link.sv
module spd_link
   import spd_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [2:0]        dev_sel,
   input  logic [7:0]        rd_byte,
   output logic [ADDR_W-1:0] ptr,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              sda_oe
);
   link_st_e            st_q;
   logic [BYTE_W-1:0]   rx_q, tx_q;
   logic [3:0]          cnt_q;
   logic                rw_q, mack_q, oe_q;
   logic [ADDR_W-1:0]   ptr_q, wr_addr_q;
   logic [7:0]          wr_data_q;
   logic                wr_req_q;
   logic                sel_hit, rx_done, tx_last;

   assign sel_hit = (rx_q[7:4] == SEL_CODE) && (rx_q[3:1] == dev_sel);
   assign rx_done = scl_fall && (cnt_q == 4'd8);
   assign tx_last = (cnt_q == 4'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         rx_q      <= '0;
         tx_q      <= '0;
         cnt_q     <= '0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         oe_q      <= 1'b0;
         ptr_q     <= '0;
         wr_req_q  <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
      end else begin
         wr_req_q <= 1'b0;
         if (start_det) begin
            st_q  <= ST_DEV;
            cnt_q <= '0;
            oe_q  <= 1'b0;
         end else if (stop_det) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
         end else begin
            case (st_q)
               ST_DEV, ST_ADDR, ST_WR: begin
                  if (scl_rise) begin
                     rx_q  <= {rx_q[6:0], sda_s};
                     cnt_q <= cnt_q + 4'd1;
                  end else if (rx_done) begin
                     cnt_q <= '0;
                     if (st_q == ST_DEV) begin
                        if (sel_hit) begin
                           rw_q <= rx_q[0];
                           oe_q <= 1'b1;
                           st_q <= ST_DEV_ACK;
                        end else begin
                           st_q <= ST_IDLE;
                        end
                     end else if (st_q == ST_ADDR) begin
                        ptr_q <= rx_q[ADDR_W-1:0];
                        oe_q  <= 1'b1;
                        st_q  <= ST_ADDR_ACK;
                     end else begin
                        wr_req_q  <= 1'b1;
                        wr_addr_q <= ptr_q;
                        wr_data_q <= rx_q;
                        ptr_q     <= ptr_q + 1'b1;
                        oe_q      <= 1'b1;
                        st_q      <= ST_WR_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        tx_q  <= rd_byte;
                        oe_q  <= ~rd_byte[7];
                        ptr_q <= ptr_q + 1'b1;
                        cnt_q <= '0;
                        st_q  <= ST_RD;
                     end else begin
                        oe_q <= 1'b0;
                        st_q <= ST_ADDR;
                     end
                  end
               end
               ST_ADDR_ACK, ST_WR_ACK: begin
                  if (scl_fall) begin
                     oe_q <= 1'b0;
                     st_q <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (tx_last) begin
                        oe_q <= 1'b0;
                        st_q <= ST_RD_ACK;
                     end else begin
                        tx_q  <= {tx_q[6:0], 1'b0};
                        oe_q  <= ~tx_q[6];
                        cnt_q <= cnt_q + 4'd1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_q  <= rd_byte;
                        oe_q  <= ~rd_byte[7];
                        ptr_q <= ptr_q + 1'b1;
                        cnt_q <= '0;
                        st_q  <= ST_RD;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign ptr     = ptr_q;
   assign wr_req  = wr_req_q;
   assign wr_addr = wr_addr_q;
   assign wr_data = wr_data_q;
   assign sda_oe  = oe_q;
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom #(
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LOCK_LOWER  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic              wp,
   input  logic [2:0]        dev_sel,
   input  logic              pre_en,
   input  logic [ADDR_W-1:0] pre_addr,
   input  logic [7:0]        pre_data
);
   if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_aw
      $error("spd_eeprom: ADDR_W must be 2..8");
   end

   logic              scl_s, sda_s, wp_s;
   logic              scl_rise, scl_fall, start_det, stop_det;
   logic [ADDR_W-1:0] ptr, wr_addr;
   logic [7:0]        wr_data, rd_byte;
   logic              wr_req, commit;

   spd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_in),
      .wp_i     (wp),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .wp_s     (wp_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   spd_link #(.ADDR_W(ADDR_W)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_s    (sda_s),
      .scl_rise (scl_rise & scl_s),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .dev_sel  (dev_sel),
      .rd_byte  (rd_byte),
      .ptr      (ptr),
      .wr_req   (wr_req),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .sda_oe   (sda_oe)
   );

   spd_store #(.ADDR_W(ADDR_W), .LOCK_LOWER(LOCK_LOWER)) u_store (
      .clk     (clk),
      .wp_s    (wp_s),
      .wr_req  (wr_req),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pre_en  (pre_en),
      .pre_addr(pre_addr),
      .pre_data(pre_data),
      .rd_addr (ptr),
      .rd_data (rd_byte),
      .commit  (commit)
   );
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl,
   input logic              sda_oe,
   input logic              start_det,
   input logic              stop_det,
   input logic              wp_s,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              commit
);
   // R3
   locked_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_addr[ADDR_W-1]) |-> !commit);

   // R4
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wp_s) |-> !commit);

   // R10
   drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl);

   // R8
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R8
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // R4
   commit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> wr_req);
endmodule

bind spd_eeprom spd_eeprom_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl      (scl),
   .sda_oe   (sda_oe),
   .start_det(start_det),
   .stop_det (stop_det),
   .wp_s     (wp_s),
   .wr_req   (wr_req),
   .wr_addr  (wr_addr),
   .commit   (commit)
);

// File: tb/spd_eeprom_tb_top.sv
module spd_eeprom_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       wp = 1'b0;
   logic [2:0] dev_sel = 3'b101;
   logic       pre_en = 1'b0;
   logic [7:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic       sda_oe;
   logic       sda;

   assign sda = ~(m_low | sda_oe);

   always #4 clk = ~clk;

   spd_eeprom dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl     (scl),
      .sda_in  (sda),
      .sda_oe  (sda_oe),
      .wp      (wp),
      .dev_sel (dev_sel),
      .pre_en  (pre_en),
      .pre_addr(pre_addr),
      .pre_data(pre_data)
   );

   localparam logic [7:0] SEL_WR = 8'hAA;
   localparam logic [7:0] SEL_RD = 8'hAB;

   int total = 0;
   int bad = 0;
   int r10_viol = 0;
   bit finished = 0;
   logic [7:0] mdl [256];
   int mptr = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R10 monitor: SDA drive must hold still while SCL stays high
   logic scl_d = 1'b1;
   logic oe_d = 1'b0;
   always @(posedge clk) begin
      #1;
      if (rst_n && scl && scl_d && (sda_oe != oe_d)) r10_viol++;
      scl_d = scl;
      oe_d  = sda_oe;
   end

   task automatic wq();
      repeat (6) @(negedge clk);
   endtask

   task automatic bus_bit(input bit v, output bit s);
      wq(); m_low = ~v;
      wq(); scl = 1'b1;
      wq(); s = sda;
      wq(); scl = 1'b0;
   endtask

   task automatic bus_start();
      m_low = 1'b0; wq();
      scl = 1'b1;   wq();
      m_low = 1'b1; wq();
      scl = 1'b0;
   endtask

   task automatic bus_stop();
      m_low = 1'b1; wq();
      scl = 1'b1;   wq();
      m_low = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         b[i] = s;
      end
      bus_bit(~mack, s);
   endtask

   task automatic read_run(input int n, input string req);
      logic [7:0] b;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, b);
         chk(b == mdl[mptr], req, b, mdl[mptr]);
         mptr = (mptr + 1) % 256;
      end
   endtask

   task automatic rand_read(input int addr, input int n, input string req);
      bit ack;
      bus_start();
      send_byte(SEL_WR, ack);
      send_byte(addr[7:0], ack);
      bus_start();
      send_byte(SEL_RD, ack);
      chk(ack, "R1 read select ack", ack, 1);
      mptr = addr;
      read_run(n, req);
      bus_stop();
   endtask

   task automatic write_seq(input int addr, input int n, input logic [7:0] d0);
      bit ack;
      bus_start();
      send_byte(SEL_WR, ack);
      chk(ack, "R1 write select ack", ack, 1);
      send_byte(addr[7:0], ack);
      chk(ack, "R2 address ack", ack, 1);
      mptr = addr;
      for (int k = 0; k < n; k++) begin
         send_byte(d0 + 8'(k), ack);
         chk(ack, "R2 data ack", ack, 1);
         if (mptr >= 128 && !wp) mdl[mptr] = d0 + 8'(k);
         mptr = (mptr + 1) % 256;
      end
      bus_stop();
   endtask

   task automatic preload(input int addr, input logic [7:0] d);
      @(negedge clk);
      pre_en = 1'b1; pre_addr = addr[7:0]; pre_data = d;
      @(negedge clk);
      pre_en = 1'b0;
      mdl[addr] = d;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] b;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R11 reset state
      chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);

      for (int a = 0; a < 256; a++) preload(a, 8'((a * 37 + 11) & 255));

      // R11 pointer at 0 after reset: address-less read
      bus_start();
      send_byte(SEL_RD, ack);
      chk(ack, "R1 select ack", ack, 1);
      mptr = 0;
      read_run(2, "R11 pointer zero");
      bus_stop();

      // R7 random read
      rand_read(5, 3, "R7 random read");
      repeat (8) @(negedge clk);
      chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);

      // R1 mismatching select byte
      bus_start();
      send_byte(8'hA4, ack);
      chk(!ack, "R1 foreign select nack", ack, 0);
      send_byte(8'h33, ack);
      chk(!ack, "R1 ignored until start", ack, 0);
      bus_stop();
      bus_start();
      send_byte(8'h5B, ack);
      chk(!ack, "R1 wrong code nack", ack, 0);
      bus_stop();

      // R3 locked lower half
      write_seq(10, 1, 8'h5A);
      rand_read(10, 1, "R3 locked byte");

      // R4 writable upper half
      write_seq(200, 2, 8'hC1);
      rand_read(200, 2, "R4 upper write");

      // R4 write protect high
      wp = 1'b1;
      write_seq(201, 1, 8'h77);
      rand_read(201, 1, "R4 protected byte");
      wp = 1'b0;

      // R3/R4 write across the wrap point
      write_seq(255, 2, 8'hE0);
      rand_read(255, 2, "R3 wrap write");

      // R5 read wrap 255 -> 0
      rand_read(254, 4, "R5 read wrap");

      // R8 current-address read continues at pointer
      bus_start();
      send_byte(SEL_RD, ack);
      read_run(2, "R8 current address");
      bus_stop();

      // R6 after NACK the block stays silent
      bus_start();
      send_byte(SEL_RD, ack);
      read_run(1, "R6 byte before nack");
      recv_byte(1'b0, b);
      chk(b == 8'hFF, "R6 silent after nack", b, 8'hFF);
      bus_stop();
      bus_start();
      send_byte(SEL_RD, ack);
      read_run(1, "R6 pointer held");
      bus_stop();

      // R2/R8 address-only write sets pointer
      bus_start();
      send_byte(SEL_WR, ack);
      send_byte(8'd77, ack);
      chk(ack, "R2 address ack", ack, 1);
      bus_stop();
      bus_start();
      send_byte(SEL_RD, ack);
      mptr = 77;
      read_run(1, "R8 pointer kept");
      bus_stop();

      // R9 preload ignores wp and reaches both halves
      wp = 1'b1;
      preload(130, 8'h3C);
      preload(3, 8'h99);
      rand_read(130, 1, "R9 preload upper");
      rand_read(3, 1, "R9 preload lower");
      wp = 1'b0;

      repeat (20) @(negedge clk);
      chk(r10_viol == 0, "R10 drive phase", r10_viol, 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule